// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block sits beside the receive and transmit FIFOs of a UART. Each cycle it works out a raw status word from the two FIFO fill levels and two programmable trigger thresholds. It folds those conditions into a sticky interrupt status word, together with single-cycle event pulses from the rest of the UART (receive overrun, receive timeout, transmit overflow, framing, parity and modem-status change). A single level interrupt line is raised whenever a sticky bit is also enabled in the interrupt mask.

Software works the block through write strobes that the bus decoder produces. One strobe sets mask bits and one clears them. A strobe for the mask register itself is accepted and then ignored. A write-one-to-clear strobe acts on the sticky word, and two more strobes load the trigger thresholds. The raw word, the sticky word and the mask are brought out as ports so that the register read path can return them. The FIFOs, the shifters and the address decoding all live outside this block.

Top module: `uart_irq_status_ctrl`

## Requirements
- R1: The raw status word is combinational on the current inputs. Bit 2 means the RX count equals the FIFO depth of 16, bit 4 means the TX count equals 16, bit 1 means the RX count is zero, bit 3 means the TX count is zero, and bit 0 means the RX count is greater than or equal to the RX trigger.
- R2: The TX-trigger condition (TX count greater than or equal to the TX trigger) appears at raw bit 13 and sets sticky bit 10. No other raw bit is ever 1.
- R3: Each raw condition in bits 0 to 4 that is true in a cycle sets the sticky bit at the same position at the next clock edge.
- R4: An event pulse sets its sticky bit at the next edge. The bits are: receive overrun 5, framing 6, parity 7, receive timeout 8, modem status 9, transmit overflow 12. Sticky bits 11 and 13 to 31 stay 0.
- R5: A clear strobe clears every sticky bit written as 1 and leaves the bits written as 0 alone. Without a clear strobe, a sticky bit never falls.
- R6: When a set (raw condition or event) meets a clear of the same bit in the same cycle, the bit ends up set.
- R7: The enable strobe ORs the write data into the 32-bit mask. The disable strobe clears the bits that are 1 in the write data. When both strobes come in one cycle, the disable wins on the bits they share.
- R8: A write strobe aimed at the mask register leaves the mask unchanged.
- R9: The interrupt output is 1 exactly when (mask AND sticky) is nonzero. It follows the registered words with no added delay.
- R10: While reset is asserted (synchronous, active low), the mask and the sticky word are 0 and both triggers hold 0x20. With that value, neither trigger condition can be true for counts up to 16.
- R11: A trigger write strobe loads bits 5:0 of the write data into its threshold. A threshold of 0 makes its trigger condition always true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_count | input | 5 | RX FIFO fill level (0 to 16) |
| tx_count | input | 5 | TX FIFO fill level (0 to 16) |
| wr_data | input | 32 | Write data shared by all strobes |
| wr_irq_en | input | 1 | Set-mask-bits strobe |
| wr_irq_dis | input | 1 | Clear-mask-bits strobe |
| wr_irq_mask | input | 1 | Direct mask write strobe (ignored) |
| wr_stat_clr | input | 1 | Write-one-to-clear strobe for the sticky word |
| wr_rx_thresh | input | 1 | Load the RX trigger threshold |
| wr_tx_thresh | input | 1 | Load the TX trigger threshold |
| ev_rx_overrun | input | 1 | Receive overrun pulse |
| ev_frame_err | input | 1 | Framing error pulse |
| ev_parity_err | input | 1 | Parity error pulse |
| ev_rx_timeout | input | 1 | Receive timeout pulse |
| ev_modem | input | 1 | Modem status change pulse |
| ev_tx_overflow | input | 1 | Transmit overflow pulse |
| raw_status | output | 32 | Live status word |
| irq_status | output | 32 | Sticky interrupt status word |
| irq_mask | output | 32 | Interrupt enable mask |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after the places where a design is most likely to go wrong.

- **TX-trigger bit mapping.** A design that copied the raw word straight across would set sticky bit 13 instead of bit 10.
- **Set-versus-clear race.** If the clear were applied after the set, an overrun pulse or a full condition would be lost in the same cycle software clears it.
- **Competing mask strobes.** Raising enable and disable together shows whether disable wins on the shared bits. A direct mask write checks that the mask stays put instead of being loaded.
- **Threshold boundaries.** Thresholds of 0, equal to the count and 0x20 test the greater-than-or-equal compare against an off-by-one. Counts of 0 and 16 expose swapped empty and full bits.

// File: rtl/uart_irq_pkg.sv
// Package: bit positions and common widths for the UART interrupt status controller.
// Assumes a 32-bit register word; positions of the status bits are fixed by software.
package uart_irq_pkg;
    localparam int STAT_W       = 32;

    // raw status positions
    localparam int RAW_RX_TRIG  = 0;
    localparam int RAW_RX_EMPTY = 1;
    localparam int RAW_RX_FULL  = 2;
    localparam int RAW_TX_EMPTY = 3;
    localparam int RAW_TX_FULL  = 4;
    localparam int RAW_TX_TRIG  = 13;

    // sticky-only positions
    localparam int STK_RX_OVR   = 5;
    localparam int STK_FRAME    = 6;
    localparam int STK_PARITY   = 7;
    localparam int STK_RX_TMO   = 8;
    localparam int STK_MODEM    = 9;
    localparam int STK_TX_TRIG  = 10;
    localparam int STK_TX_OVF   = 12;

    // number of raw bits copied one to one into the sticky word
    localparam int DIRECT_BITS  = 5;
endpackage

// File: rtl/uart_irq_thresh_reg.sv
// Module: one programmable trigger threshold register.
// Assumes the write strobe is a single-cycle pulse from the bus decoder.
module uart_irq_thresh_reg #(
    parameter int               TRIG_W   = 6,
    parameter logic [TRIG_W-1:0] RST_VAL = 6'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TRIG_W-1:0] load_val,
    output logic [TRIG_W-1:0] thresh
);
    // hold the threshold, reload on a write strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     thresh <= RST_VAL;
        else if (load)  thresh <= load_val;
    end

    AST_THRESH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (thresh == $past(load_val)));                         // R11
endmodule

// File: rtl/uart_irq_raw_status.sv
// Module: combinational raw status from FIFO levels and trigger thresholds.
// Also produces the set vector that feeds the sticky word, with the TX trigger
// moved from its raw position to its sticky position.
// Assumes counts never exceed DEPTH.
module uart_irq_raw_status
    import uart_irq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 5,
    parameter int TRIG_W = 6
) (
    input  logic [CNT_W-1:0]  rx_cnt,
    input  logic [CNT_W-1:0]  tx_cnt,
    input  logic [TRIG_W-1:0] rx_trig,
    input  logic [TRIG_W-1:0] tx_trig,
    output logic [STAT_W-1:0] raw_word,
    output logic [STAT_W-1:0] raw_set
);
    localparam int CMP_W = (CNT_W > TRIG_W) ? CNT_W : TRIG_W;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CMP_W-1:0] rx_cnt_x, tx_cnt_x, rx_trig_x, tx_trig_x;
    logic rx_at_trig, tx_at_trig;

    // widen both sides of the trigger compares to a common width
    always_comb begin
        rx_cnt_x  = CMP_W'(rx_cnt);
        tx_cnt_x  = CMP_W'(tx_cnt);
        rx_trig_x = CMP_W'(rx_trig);
        tx_trig_x = CMP_W'(tx_trig);
        rx_at_trig = (rx_cnt_x >= rx_trig_x);
        tx_at_trig = (tx_cnt_x >= tx_trig_x);
    end

    // assemble the raw status word
    always_comb begin
        raw_word               = '0;
        raw_word[RAW_RX_TRIG]  = rx_at_trig;
        raw_word[RAW_RX_EMPTY] = (rx_cnt == '0);
        raw_word[RAW_RX_FULL]  = (rx_cnt == FULL_CNT);
        raw_word[RAW_TX_EMPTY] = (tx_cnt == '0);
        raw_word[RAW_TX_FULL]  = (tx_cnt == FULL_CNT);
        raw_word[RAW_TX_TRIG]  = tx_at_trig;
    end

    // map raw conditions onto sticky positions
    always_comb begin
        raw_set                        = '0;
        raw_set[DIRECT_BITS-1:0]       = raw_word[DIRECT_BITS-1:0];
        raw_set[STK_TX_TRIG]           = raw_word[RAW_TX_TRIG];
    end

    always_comb begin
        AST_EMPTY_FULL_EXCL: assert (!(raw_word[RAW_RX_EMPTY] && raw_word[RAW_RX_FULL])); // R1
    end
endmodule

// File: rtl/uart_irq_sticky.sv
// Module: sticky interrupt status word with write-one-to-clear.
// A set request in the same cycle as a clear of that bit wins.
// Assumes set_vec holds only implemented bit positions.
module uart_irq_sticky #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_en,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] sticky_q
);
    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            // one sticky bit: set beats clear, otherwise hold
            always_ff @(posedge clk) begin
                if (!rst_n)                      sticky_q[b] <= 1'b0;
                else if (set_vec[b])             sticky_q[b] <= 1'b1;
                else if (clr_en && clr_vec[b])   sticky_q[b] <= 1'b0;
            end
        end
    endgenerate

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((sticky_q & $past(set_vec)) == $past(set_vec)));     // R6
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((sticky_q & $past(clr_vec & ~set_vec)) == '0));               // R5
    AST_NO_SPONTANEOUS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));           // R5
endmodule

// File: rtl/uart_irq_mask.sv
// Module: interrupt enable mask driven by set and clear strobes.
// A direct write strobe is accepted and has no effect; disable wins over enable.
module uart_irq_mask #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_wr,
    input  logic         dis_wr,
    input  logic         direct_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);
    logic [W-1:0] after_en, mask_d;

    // apply the enable, then the disable, to form the next mask
    always_comb begin
        after_en = en_wr  ? (mask_q | wdata)    : mask_q;
        mask_d   = dis_wr ? (after_en & ~wdata) : after_en;
    end

    // register the mask
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    AST_DIRECT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_wr && !en_wr && !dis_wr) |=> $stable(mask_q));                   // R8
    AST_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !dis_wr) |=> ((mask_q & $past(wdata)) == $past(wdata)));       // R7
    AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        dis_wr |=> ((mask_q & $past(wdata)) == '0));                             // R7
endmodule

// File: rtl/uart_irq_status_ctrl.sv
// Module: UART interrupt status controller (top).
// Combines the raw FIFO status, event pulses and software strobes into a sticky
// status word, an enable mask and one level interrupt.
// Assumes strobes and events are single-cycle and counts stay within FIFO_DEPTH.
module uart_irq_status_ctrl
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int TRIG_W     = 6,
    parameter int TRIG_RST   = 32,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [STAT_W-1:0] wr_data,
    input  logic              wr_irq_en,
    input  logic              wr_irq_dis,
    input  logic              wr_irq_mask,
    input  logic              wr_stat_clr,
    input  logic              wr_rx_thresh,
    input  logic              wr_tx_thresh,
    input  logic              ev_rx_overrun,
    input  logic              ev_frame_err,
    input  logic              ev_parity_err,
    input  logic              ev_rx_timeout,
    input  logic              ev_modem,
    input  logic              ev_tx_overflow,
    output logic [STAT_W-1:0] raw_status,
    output logic [STAT_W-1:0] irq_status,
    output logic [STAT_W-1:0] irq_mask,
    output logic              irq
);
    localparam logic [TRIG_W-1:0] TRIG_RST_V = TRIG_W'(TRIG_RST);

    logic [TRIG_W-1:0] rx_trig, tx_trig;
    logic [STAT_W-1:0] raw_set, event_set, set_all;

    uart_irq_thresh_reg #(.TRIG_W(TRIG_W), .RST_VAL(TRIG_RST_V)) u_rx_thresh (
        .clk(clk), .rst_n(rst_n), .load(wr_rx_thresh),
        .load_val(wr_data[TRIG_W-1:0]), .thresh(rx_trig));

    uart_irq_thresh_reg #(.TRIG_W(TRIG_W), .RST_VAL(TRIG_RST_V)) u_tx_thresh (
        .clk(clk), .rst_n(rst_n), .load(wr_tx_thresh),
        .load_val(wr_data[TRIG_W-1:0]), .thresh(tx_trig));

    uart_irq_raw_status #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .TRIG_W(TRIG_W)) u_raw (
        .rx_cnt(rx_count), .tx_cnt(tx_count), .rx_trig(rx_trig), .tx_trig(tx_trig),
        .raw_word(raw_status), .raw_set(raw_set));

    // place the event pulses at their sticky positions and merge with raw sets
    always_comb begin
        event_set             = '0;
        event_set[STK_RX_OVR] = ev_rx_overrun;
        event_set[STK_FRAME]  = ev_frame_err;
        event_set[STK_PARITY] = ev_parity_err;
        event_set[STK_RX_TMO] = ev_rx_timeout;
        event_set[STK_MODEM]  = ev_modem;
        event_set[STK_TX_OVF] = ev_tx_overflow;
        set_all               = raw_set | event_set;
    end

    uart_irq_sticky #(.W(STAT_W)) u_sticky (
        .clk(clk), .rst_n(rst_n), .set_vec(set_all),
        .clr_en(wr_stat_clr), .clr_vec(wr_data), .sticky_q(irq_status));

    uart_irq_mask #(.W(STAT_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .en_wr(wr_irq_en), .dis_wr(wr_irq_dis),
        .direct_wr(wr_irq_mask), .wdata(wr_data), .mask_q(irq_mask));

    // level interrupt from enabled sticky bits
    always_comb begin
        irq = |(irq_mask & irq_status);
    end

    AST_RAW_TO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        raw_status[RAW_RX_EMPTY] |=> irq_status[RAW_RX_EMPTY]);              // R3
    AST_TXTRIG_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
        raw_status[RAW_TX_TRIG] |=> irq_status[STK_TX_TRIG]);                // R2
    AST_OVERRUN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_overrun |=> irq_status[STK_RX_OVR]);                           // R4
    AST_UNUSED_STICKY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status[STAT_W-1:13] == '0) && !irq_status[11]);                 // R4
endmodule

// File: tb/uart_irq_status_ctrl_test.sv
`timescale 1ns/1ps
module uart_irq_status_ctrl_test;
    localparam int TW = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rx_count, tx_count;
    logic [31:0] wr_data;
    logic        wr_irq_en, wr_irq_dis, wr_irq_mask, wr_stat_clr, wr_rx_thresh, wr_tx_thresh;
    logic        ev_rx_overrun, ev_frame_err, ev_parity_err, ev_rx_timeout, ev_modem, ev_tx_overflow;
    logic [31:0] raw_status, irq_status, irq_mask;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_mask, m_sticky;
    logic [TW-1:0] m_rxt, m_txt;

    always #5 clk = ~clk;

    uart_irq_status_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
        .wr_data(wr_data), .wr_irq_en(wr_irq_en), .wr_irq_dis(wr_irq_dis),
        .wr_irq_mask(wr_irq_mask), .wr_stat_clr(wr_stat_clr),
        .wr_rx_thresh(wr_rx_thresh), .wr_tx_thresh(wr_tx_thresh),
        .ev_rx_overrun(ev_rx_overrun), .ev_frame_err(ev_frame_err),
        .ev_parity_err(ev_parity_err), .ev_rx_timeout(ev_rx_timeout),
        .ev_modem(ev_modem), .ev_tx_overflow(ev_tx_overflow),
        .raw_status(raw_status), .irq_status(irq_status), .irq_mask(irq_mask), .irq(irq));

    // expected raw word from the requirements (R1, R2)
    function automatic logic [31:0] exp_raw(input logic [4:0] rc, input logic [4:0] tc,
                                            input logic [TW-1:0] rt, input logic [TW-1:0] tt);
        logic [31:0] r = '0;
        r[0]  = ({1'b0, rc} >= rt);
        r[1]  = (rc == 0);
        r[2]  = (rc == 16);
        r[3]  = (tc == 0);
        r[4]  = (tc == 16);
        r[13] = ({1'b0, tc} >= tt);
        return r;
    endfunction

    // sticky set vector from raw conditions and events (R3, R4, R2)
    function automatic logic [31:0] exp_set(input logic [31:0] r);
        logic [31:0] s = '0;
        s[4:0] = r[4:0];
        s[10]  = r[13];
        s[5]   = ev_rx_overrun;
        s[6]   = ev_frame_err;
        s[7]   = ev_parity_err;
        s[8]   = ev_rx_timeout;
        s[9]   = ev_modem;
        s[12]  = ev_tx_overflow;
        return s;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_data = '0; wr_irq_en = 0; wr_irq_dis = 0; wr_irq_mask = 0; wr_stat_clr = 0;
        wr_rx_thresh = 0; wr_tx_thresh = 0;
        ev_rx_overrun = 0; ev_frame_err = 0; ev_parity_err = 0;
        ev_rx_timeout = 0; ev_modem = 0; ev_tx_overflow = 0;
    endtask

    // inputs set at a falling edge; checks raw now, registered words after the rising edge
    task automatic step(input string tag);
        logic [31:0] r, nm;
        #1;
        r = exp_raw(rx_count, tx_count, m_rxt, m_txt);
        chk(raw_status, r, {tag, " raw (R1 R2)"});
        @(posedge clk);
        m_sticky = (m_sticky & ~(wr_stat_clr ? wr_data : 32'h0)) | exp_set(r);
        nm = wr_irq_en ? (m_mask | wr_data) : m_mask;
        m_mask = wr_irq_dis ? (nm & ~wr_data) : nm;
        if (wr_rx_thresh) m_rxt = wr_data[TW-1:0];
        if (wr_tx_thresh) m_txt = wr_data[TW-1:0];
        @(negedge clk);
        chk(irq_status, m_sticky, {tag, " sticky (R3 R4 R5 R6)"});
        chk(irq_mask, m_mask, {tag, " mask (R7 R8)"});
        chk({31'b0, irq}, {31'b0, |(m_mask & m_sticky)}, {tag, " irq (R9)"});
        idle_inputs();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        rx_count = 5'd16; tx_count = 5'd16;
        idle_inputs();
        m_mask = '0; m_sticky = '0; m_rxt = 6'h20; m_txt = 6'h20;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset values; triggers at 0x20 keep trigger bits low at full counts
        chk(irq_status, 32'h0, "R10 sticky in reset");
        chk(irq_mask, 32'h0, "R10 mask in reset");
        chk(raw_status, 32'h0000_0014, "R10 raw with reset triggers");
        chk({31'b0, irq}, 32'h0, "R10 irq in reset");
        rx_count = 0; tx_count = 0;
        rst_n = 1'b1;
        step("R3 empty after reset");

        // R6: clearing everything while empty conditions stay true
        wr_stat_clr = 1; wr_data = 32'hFFFF_FFFF;
        step("R6 clear vs live raw");
        rx_count = 3; tx_count = 3;
        wr_stat_clr = 1; wr_data = 32'hFFFF_FFFF;
        step("R5 clear all");
        // R6 event with same-cycle clear
        ev_rx_overrun = 1; wr_stat_clr = 1; wr_data = 32'h0000_0020;
        step("R6 overrun vs clear");
        // R4 all events at once
        ev_frame_err = 1; ev_parity_err = 1; ev_rx_timeout = 1; ev_modem = 1; ev_tx_overflow = 1;
        step("R4 events");
        // R5 partial clear
        wr_stat_clr = 1; wr_data = 32'h0000_1140;
        step("R5 partial clear");
        // R7 enable
        wr_irq_en = 1; wr_data = 32'h0000_0120;
        step("R7 enable");
        // R8 direct mask write
        wr_irq_mask = 1; wr_data = 32'hFFFF_FFFF;
        step("R8 direct mask write");
        // R7 both strobes, disable wins
        wr_irq_en = 1; wr_irq_dis = 1; wr_data = 32'h0000_0421;
        step("R7 enable and disable");
        // R11 thresholds to 0 and boundary equality
        wr_rx_thresh = 1; wr_data = 32'h0;
        step("R11 rx thresh 0");
        wr_tx_thresh = 1; wr_data = 32'h3;
        step("R11 tx thresh 3");
        step("R2 tx trigger at equality");
        tx_count = 2;
        step("R11 tx below trigger");
        rx_count = 16; tx_count = 16;
        wr_irq_en = 1; wr_data = 32'hFFFF_FFFF;
        step("R1 full counts");
        wr_stat_clr = 1; wr_data = 32'hFFFF_FFFF; rx_count = 5; tx_count = 5;
        step("R9 irq after clear");

        // random mix (R1 R2 R3 R4 R5 R7 R9 R11)
        for (int i = 0; i < 3000; i++) begin
            rx_count = 5'($urandom_range(0, 16));
            tx_count = 5'($urandom_range(0, 16));
            wr_data  = $urandom;
            if ($urandom_range(0, 7) == 0) wr_data[5:0] = 6'($urandom_range(0, 18));
            wr_irq_en    = ($urandom_range(0, 5) == 0);
            wr_irq_dis   = ($urandom_range(0, 5) == 0);
            wr_irq_mask  = ($urandom_range(0, 5) == 0);
            wr_stat_clr  = ($urandom_range(0, 3) == 0);
            wr_rx_thresh = ($urandom_range(0, 9) == 0);
            wr_tx_thresh = ($urandom_range(0, 9) == 0);
            ev_rx_overrun  = ($urandom_range(0, 7) == 0);
            ev_frame_err   = ($urandom_range(0, 7) == 0);
            ev_parity_err  = ($urandom_range(0, 7) == 0);
            ev_rx_timeout  = ($urandom_range(0, 7) == 0);
            ev_modem       = ($urandom_range(0, 7) == 0);
            ev_tx_overflow = ($urandom_range(0, 7) == 0);
            step("random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule